// File: doc/BRIEF.md
# Collision-Vector Pipeline Initiation Controller

This block guards the entry of a non-linear pipeline whose stage usage is fixed by a reservation table. The table is summarised at build time as a collision vector: one bit per latency from 1 up to the task length minus one. A set bit means that starting a new task that many cycles after an earlier one would make two tasks need the same stage in the same cycle. The controller keeps a live copy of that vector as a state register and uses it each cycle to decide whether a waiting task may enter.

Each idle cycle the state moves one place toward the low end, and a zero is shifted in at the top. The low bit answers the question "is a start in this cycle forbidden?". When a task is granted, the shifted state is ORed with the collision vector, so the restrictions of every task still in flight are kept. Refused requests are counted and released by themselves at the first legal cycle. A spacing input can hold grants off until a minimum number of cycles has elapsed. Two counters report the cycles since the last grant and the spacing between the last two grants.

Top module: `cv_init_ctrl`

## Requirements
- R1: While and after synchronous reset, with no request, `state_o` is 0, `since_o` is all ones (2^LAT_W-1), `gap_o` is 0, `pend_o` is 0 and `grant_o` is 0.
- R2: `grant_o` rises in the same cycle as a request (`req_i` high or `pend_o` nonzero) when `state_o[0]` is 0 and the spacing condition of R10 holds. Because the state is zero out of reset, the first request after reset is granted at once.
- R3: In the cycle after a grant, `state_o` equals the previous `state_o` shifted right by one, ORed with the collision vector `CV`. Bit k of `CV` stands for latency k+1.
- R4: In the cycle after a cycle without a grant, `state_o` equals the previous value shifted right by one, with a zero entering at the top bit.
- R5: When `state_o[0]` is 1, `grant_o` stays low whatever the request inputs are.
- R6: A request made TASK_LEN or more cycles after the last grant is always granted. With the default `CV` = 1011010 (bit 6 down to bit 0), a start at latency 1 leaves state 1111111, and a start at latency 8 after that brings the state back to 1011010.
- R7: A refused request increments `pend_o`. While `pend_o` is nonzero, a grant happens at the first permissible cycle without `req_i` being held, and each grant lowers `pend_o` by one.
- R8: `pend_o` saturates at 2^PEND_W-1. Further refused requests are dropped. A request in a cycle that grants an older waiting request is still counted.
- R9: In greedy mode (`greedy_i`=1) with a request every cycle, vector 100010 gives grants at latencies 1, 3, 1, 3, and vector 1011 gives a grant every 3 cycles.
- R10: With `greedy_i`=0, a grant also requires `since_o` >= `min_gap_i`, and it never overrides a forbidden latency. For vector 1011 with a minimum gap of 4, grants come every 5 cycles.
- R11: `since_o` is 1 in the cycle after a grant, then rises by one per cycle and saturates at 2^LAT_W-1. On each grant, `gap_o` takes the `since_o` value of the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One task asks to enter this cycle |
| greedy_i | input | 1 | 1: grant at the first permissible cycle; 0: also honour `min_gap_i` |
| min_gap_i | input | LAT_W | Minimum spacing between grants when not greedy |
| grant_o | output | 1 | A task enters the pipeline this cycle |
| state_o | output | TASK_LEN-1 | Current collision state; bit k = latency k+1 forbidden |
| since_o | output | LAT_W | Cycles since the last grant, saturating |
| gap_o | output | LAT_W | Spacing of the two most recent grants |
| pend_o | output | PEND_W | Refused requests still waiting |

## Verification
The bench drives the latency-1 start that fills the state with ones, then checks that the refusal lasts exactly seven cycles and that the state returns to the vector at latency 8. A design that ORs before shifting, or that shifts by the wrong amount, would grant early or fail to restore the vector. The bench lets a single refused pulse wait with the request line low, to catch a design that drops waiting work. It fills the waiting count beyond its limit, where a wrapping counter would lose almost every request. The bench also drives the two repeating latency patterns and the spacing mode on vector 1011. That last case shows that a minimum gap landing on a forbidden latency pushes the grant one cycle further, instead of forcing a collision.

// File: rtl/cv_pkg.sv
package cv_pkg;
  localparam int unsigned DEF_TASK_LEN = 8;
  localparam logic [DEF_TASK_LEN-2:0] DEF_CV = 7'b1011010;
  localparam int unsigned DEF_LAT_W = 5;
  localparam int unsigned DEF_PEND_W = 2;
endpackage

// File: rtl/cv_state.sv
module cv_state #(
  parameter int unsigned VEC_W = 7,
  parameter logic [VEC_W-1:0] CV = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  output logic [VEC_W-1:0] state_o,
  output logic             free_o
);
  logic [VEC_W-1:0] st_q;
  logic [VEC_W-1:0] st_d;

  // each bit takes its upper neighbour; on a start the vector is merged in
  for (genvar k = 0; k < VEC_W; k++) begin : g_bit
    if (k == VEC_W - 1) begin : g_top
      assign st_d[k] = fire_i & CV[k];
    end else begin : g_mid
      assign st_d[k] = st_q[k+1] | (fire_i & CV[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign state_o = st_q;
  assign free_o  = ~st_q[0];
endmodule

// File: rtl/cv_latency.sv
module cv_latency #(
  parameter int unsigned LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  output logic [LAT_W-1:0] since_o,
  output logic [LAT_W-1:0] gap_o
);
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};
  localparam logic [LAT_W-1:0] LAT_ONE = {{(LAT_W-1){1'b0}}, 1'b1};

  logic [LAT_W-1:0] since_q;
  logic [LAT_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= LAT_MAX;
      gap_q   <= '0;
    end else if (fire_i) begin
      gap_q   <= since_q;
      since_q <= LAT_ONE;
    end else if (since_q != LAT_MAX) begin
      since_q <= since_q + LAT_ONE;
    end
  end

  assign since_o = since_q;
  assign gap_o   = gap_q;
endmodule

// File: rtl/cv_pending.sv
module cv_pending #(
  parameter int unsigned PEND_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              fire_i,
  output logic              wait_o,
  output logic [PEND_W-1:0] count_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};
  localparam logic [PEND_W-1:0] PEND_ONE = {{(PEND_W-1){1'b0}}, 1'b1};

  logic [PEND_W-1:0] cnt_q;
  logic              take;

  // a request is kept unless the count is full and nothing leaves
  assign take = req_i & ((cnt_q != PEND_MAX) | fire_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({take, fire_i})
        2'b10:   cnt_q <= cnt_q + PEND_ONE;
        2'b01:   cnt_q <= cnt_q - PEND_ONE;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wait_o  = (cnt_q != '0);
  assign count_o = cnt_q;
endmodule

// File: rtl/cv_init_ctrl.sv
module cv_init_ctrl
  import cv_pkg::*;
#(
  parameter int unsigned TASK_LEN = DEF_TASK_LEN,
  parameter logic [TASK_LEN-2:0] CV = DEF_CV,
  parameter int unsigned LAT_W = DEF_LAT_W,
  parameter int unsigned PEND_W = DEF_PEND_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic                greedy_i,
  input  logic [LAT_W-1:0]    min_gap_i,
  output logic                grant_o,
  output logic [TASK_LEN-2:0] state_o,
  output logic [LAT_W-1:0]    since_o,
  output logic [LAT_W-1:0]    gap_o,
  output logic [PEND_W-1:0]   pend_o
);
  localparam int unsigned VEC_W = TASK_LEN - 1;

  logic free;
  logic waiting;
  logic spaced;
  logic fire;

  assign spaced  = greedy_i | (since_o >= min_gap_i);
  assign fire    = (req_i | waiting) & free & spaced;
  assign grant_o = fire;

  cv_state #(.VEC_W(VEC_W), .CV(CV)) u_state (
    .clk(clk), .rst(rst), .fire_i(fire), .state_o(state_o), .free_o(free)
  );

  cv_latency #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst(rst), .fire_i(fire), .since_o(since_o), .gap_o(gap_o)
  );

  cv_pending #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst(rst), .req_i(req_i), .fire_i(fire),
    .wait_o(waiting), .count_o(pend_o)
  );
endmodule

// File: rtl/cv_init_chk.sv
module cv_init_chk #(
  parameter int unsigned VEC_W = 7,
  parameter logic [VEC_W-1:0] CV = '0,
  parameter int unsigned LAT_W = 5,
  parameter int unsigned PEND_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              greedy_i,
  input logic [LAT_W-1:0]  min_gap_i,
  input logic              grant_o,
  input logic [VEC_W-1:0]  state_o,
  input logic [LAT_W-1:0]  since_o,
  input logic [LAT_W-1:0]  gap_o,
  input logic [PEND_W-1:0] pend_o
);
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

  AST_FORBIDDEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    state_o[0] |-> !grant_o); // R5
  AST_START_MERGE: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> state_o == (($past(state_o) >> 1) | CV)); // R3
  AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !grant_o |=> state_o == ($past(state_o) >> 1)); // R4
  AST_WAITING_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pend_o != '0 && !state_o[0] && greedy_i) |-> grant_o); // R7
  AST_SPACING_KEPT: assert property (@(posedge clk) disable iff (rst)
    (grant_o && !greedy_i) |-> since_o >= min_gap_i); // R10
  AST_SINCE_RESTART: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> since_o == 1); // R11
  AST_SINCE_CAPPED: assert property (@(posedge clk) disable iff (rst)
    (!grant_o && since_o == LAT_MAX) |=> since_o == LAT_MAX); // R11
  AST_GAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> gap_o == $past(since_o)); // R11
endmodule

bind cv_init_ctrl cv_init_chk #(
  .VEC_W(VEC_W), .CV(CV), .LAT_W(LAT_W), .PEND_W(PEND_W)
) u_chk (
  .clk(clk), .rst(rst), .greedy_i(greedy_i), .min_gap_i(min_gap_i),
  .grant_o(grant_o), .state_o(state_o), .since_o(since_o),
  .gap_o(gap_o), .pend_o(pend_o)
);

// File: tb/sim_cv_init_ctrl.sv
module sim_cv_init_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic greedy = 1'b1;
  logic [4:0] min_gap = '0;
  logic rq0 = 1'b0, rq1 = 1'b0, rq2 = 1'b0;
  logic g0, g1, g2;
  logic [6:0] st0;
  logic [5:0] st1;
  logic [3:0] st2;
  logic [4:0] since0, since1, since2, gap0, gap1, gap2;
  logic [1:0] pend0, pend1, pend2;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cv_init_ctrl u0 (
    .clk(clk), .rst(rst), .req_i(rq0), .greedy_i(greedy), .min_gap_i(min_gap),
    .grant_o(g0), .state_o(st0), .since_o(since0), .gap_o(gap0), .pend_o(pend0));
  cv_init_ctrl #(.TASK_LEN(7), .CV(6'b100010)) u1 (
    .clk(clk), .rst(rst), .req_i(rq1), .greedy_i(greedy), .min_gap_i(min_gap),
    .grant_o(g1), .state_o(st1), .since_o(since1), .gap_o(gap1), .pend_o(pend1));
  cv_init_ctrl #(.TASK_LEN(5), .CV(4'b1011)) u2 (
    .clk(clk), .rst(rst), .req_i(rq2), .greedy_i(greedy), .min_gap_i(min_gap),
    .grant_o(g2), .state_o(st2), .since_o(since2), .gap_o(gap2), .pend_o(pend2));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // set inputs at the falling edge, sample one step later
  task automatic step(input logic r0, input logic r1, input logic r2);
    @(negedge clk);
    rq0 = r0; rq1 = r1; rq2 = r2;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rq0 = 0; rq1 = 0; rq2 = 0; greedy = 1'b1; min_gap = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    step(0, 0, 0);
    check("R1 state", st0, 0);
    check("R1 since", since0, 31);
    check("R1 gap", gap0, 0);
    check("R1 pend", pend0, 0);
    check("R1 grant", g0, 0);
  endtask

  task automatic t_fill_and_restore();
    do_reset();
    step(1, 0, 0);
    check("R2 first request at once", g0, 1);
    step(1, 0, 0);
    check("R3 state after first start", st0, 7'b1011010);
    check("R2 latency 1 allowed", g0, 1);
    step(1, 0, 0);
    check("R6 state after latency 1", st0, 7'b1111111);
    check("R5 refused", g0, 0);
    step(0, 0, 0);
    check("R7 pending kept", pend0, 1);
    check("R4 shift one", st0, 7'b0111111);
    check("R5 still refused", g0, 0);
    step(0, 0, 0);
    check("R4 shift two", st0, 7'b0011111);
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0);
      check("R5 refused during wait", g0, 0);
    end
    step(0, 0, 0);
    check("R6 state emptied", st0, 0);
    check("R7 automatic grant", g0, 1);
    check("R11 since at grant", since0, 8);
    step(0, 0, 0);
    check("R6 vector restored", st0, 7'b1011010);
    check("R11 gap latency 8", gap0, 8);
    check("R11 since restarts", since0, 1);
    check("R7 pending drained", pend0, 0);
    check("R7 no extra grant", g0, 0);
  endtask

  task automatic t_saturate();
    int n = 0;
    do_reset();
    step(1, 0, 0);
    step(1, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    step(0, 0, 0);
    check("R8 pending saturated", pend0, 3);
    if (g0) n++;
    for (int i = 0; i < 30; i++) begin
      step(0, 0, 0);
      if (g0) n++;
    end
    check("R8 grants from saturated count", n, 3);
    check("R8 pending empty", pend0, 0);
  endtask

  task automatic t_greedy_patterns();
    do_reset();
    for (int i = 0; i < 12; i++) begin
      step(0, 1, 1);
      check("R9 vector 100010 pattern", g1, ((i % 4) < 2) ? 1 : 0);
      check("R9 vector 1011 pattern", g2, ((i % 3) == 0) ? 1 : 0);
    end
  endtask

  task automatic t_spacing();
    do_reset();
    greedy = 1'b0;
    min_gap = 5'd4;
    for (int i = 0; i < 15; i++) begin
      step(0, 0, 1);
      check("R10 spacing on 1011", g2, ((i % 5) == 0) ? 1 : 0);
    end
  endtask

  task automatic t_since_sat();
    do_reset();
    step(1, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 0);
    check("R11 since saturates", since0, 31);
    step(1, 0, 0);
    check("R2 grant after long idle", g0, 1);
    step(0, 0, 0);
    check("R11 gap saturated", gap0, 31);
    check("R11 since after grant", since0, 1);
  endtask

  initial begin
    t_reset();
    t_fill_and_restore();
    t_saturate();
    t_greedy_patterns();
    t_spacing();
    t_since_sat();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule